// File: doc/BRIEF.md
# FSK Transmit Framer with Tone Synthesiser

This block turns bytes written by a host over a simple clocked serial input into 1200 bit/s asynchronous characters and modulates them as two-tone frequency-shift keying. Each character is wrapped with a low start bit and a high stop bit. When the host has nothing queued, the line rests at mark for at least five bit times before another character may begin. When transmit mode is switched on, the block can either run continuous mark until the first byte arrives or stay silent until that byte is written.

The tones come from a phase accumulator clocked at 3.579545 MHz. A plan-select pin chooses between two mark/space frequency pairs. The accumulator phase carries on unbroken when the tone changes, and the tone changes only at bit boundaries. The outputs are the accumulator's top bit and a folded (triangle) amplitude code taken from its upper bits, which an external converter turns into a waveform. A ready flag tells the host when the single holding slot can take another byte.

Top module: `fsk_tx_framer`

## Requirements
- R1: During and after reset, with `send_en` low: `ready`=1, `line_bit`=1, `tone_on`=0, `tone_msb`=0 and `tone_code`=0.
- R2: The host shifts a byte in LSB first, one bit per rising edge of `ser_clk`. Each edge passes through a two-stage synchroniser and takes effect on the third `clk` edge after the first edge that samples it. `ready` falls when the eighth bit lands. It rises on the clock edge that moves the byte into a frame. Serial edges that arrive while `ready` is low are ignored.
- R3: A frame is a start bit (`line_bit`=0), then eight data bits LSB first, then a stop bit (1). Each bit lasts BIT_CYC = round(F_CLK/BAUD) = 2983 clocks.
- R4: If a byte is pending when a stop bit ends, the next start bit follows at once. Otherwise the line idles at mark for at least IDLE_MIN (5) bits, and a frame begins at the first bit boundary, from the fifth onward, at which a byte is pending.
- R5: A rising `send_en` with `pre_hold` low starts continuous mark with the tone running. The first start bit begins at the first bit boundary at which a byte is pending, no more than one bit time (≤ 0.83 ms) after the byte completes.
- R6: A rising `send_en` with `pre_hold` high keeps `tone_on` low and the accumulator frozen until a byte is pending. The start bit then begins on the following clock.
- R7: With `plan_sel`=1, mark is 1200 Hz and space is 2204 Hz. With `plan_sel`=0, mark is 1300 Hz and space is 2101 Hz. Step = round(f·2^24/F_CLK). `plan_sel` and the bit value are taken up only at bit boundaries and at mode entry.
- R8: While `tone_on` is high, the 24-bit accumulator adds the current step on every clock, with no phase reset. `tone_msb` is its bit 23. `tone_code` is bits 22:15, inverted when bit 23 is 1.
- R9: While `send_en` is low, the accumulator is zero, `tone_on`=0, `line_bit`=1, and any frame in progress is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, nominally 3.579545 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| send_en | input | 1 | Transmit mode enable |
| pre_hold | input | 1 | 0: mark run on entry; 1: silent until the first byte |
| plan_sel | input | 1 | Tone plan select (1: 1200/2204 Hz, 0: 1300/2101 Hz) |
| ser_clk | input | 1 | Host serial clock |
| ser_data | input | 1 | Host serial data, LSB first |
| ready | output | 1 | Holding slot free |
| line_bit | output | 1 | Current line bit, 1 = mark |
| tone_on | output | 1 | Synthesiser running |
| tone_msb | output | 1 | Accumulator top bit (square tone) |
| tone_code | output | 8 | Folded amplitude code |

## Verification
The hardest case to reach is a byte that arrives part-way through an idle gap. It must wait for exactly the fifth idle boundary, neither earlier nor later. The bench reaches it by waiting until its own line decoder has seen the stop bit of a back-to-back frame, then writing the next byte one bit time later. It checks the spacing between start bits. Before that, a second write is issued while the holding slot is full, and the bench confirms that this byte never appears on the line.

// File: rtl/fsk_tx_pkg.sv
package fsk_tx_pkg;

   typedef enum logic [2:0] {
      ST_OFF,
      ST_WAIT,
      ST_PRE,
      ST_IDLE,
      ST_DATA
   } tx_state_e;

   // Phase increment for a tone of f_hz at clock f_clk, rounded to nearest.
   function automatic logic [63:0] tone_step(input longint f_hz, input longint f_clk,
                                              input int acc_w);
      return 64'(((f_hz <<< acc_w) + f_clk / 2) / f_clk);
   endfunction

endpackage

// File: rtl/fsk_host_rx.sv
module fsk_host_rx #(
   parameter int SYNC_LEN = 2,
   parameter int BYTE_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_data,
   input  logic              take,
   output logic              full,
   output logic [BYTE_W-1:0] hold
);
   localparam int CNT_W = $clog2(BYTE_W);

   logic [SYNC_LEN:0]   ck_pipe;
   logic [SYNC_LEN-1:0] dt_pipe;
   logic [CNT_W-1:0]    cnt_q;
   logic [BYTE_W-1:0]   asm_q;
   logic                full_q;
   logic [BYTE_W-1:0]   hold_q;
   logic                rise;
   logic                dbit;

   assign rise = ck_pipe[SYNC_LEN-1] & ~ck_pipe[SYNC_LEN];
   assign dbit = dt_pipe[SYNC_LEN-1];
   assign full = full_q;
   assign hold = hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_pipe <= '0;
         dt_pipe <= '0;
         cnt_q   <= '0;
         asm_q   <= '0;
         full_q  <= 1'b0;
         hold_q  <= '0;
      end else begin
         ck_pipe <= {ck_pipe[SYNC_LEN-1:0], ser_clk};
         dt_pipe <= {dt_pipe[SYNC_LEN-2:0], ser_data};
         if (take) begin
            full_q <= 1'b0;
         end else if (rise && !full_q) begin
            asm_q <= {dbit, asm_q[BYTE_W-1:1]};
            if (cnt_q == CNT_W'(BYTE_W - 1)) begin
               hold_q <= {dbit, asm_q[BYTE_W-1:1]};
               full_q <= 1'b1;
               cnt_q  <= '0;
            end else begin
               cnt_q <= cnt_q + CNT_W'(1);
            end
         end
      end
   end

   AST_TAKE_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> full_q) else $error("take without pending byte"); // R2
   AST_HOLD_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      full_q |=> $stable(hold_q)) else $error("holding byte overwritten"); // R2
endmodule

// File: rtl/fsk_frame_seq.sv
module fsk_frame_seq
   import fsk_tx_pkg::*;
#(
   parameter int F_CLK      = 3579545,
   parameter int BAUD       = 1200,
   parameter int ACC_W      = 24,
   parameter int IDLE_MIN   = 5,
   parameter int BYTE_W     = 8,
   parameter int MARK_A_HZ  = 1200,
   parameter int SPACE_A_HZ = 2204,
   parameter int MARK_B_HZ  = 1300,
   parameter int SPACE_B_HZ = 2101
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              send_en,
   input  logic              pre_hold,
   input  logic              plan_sel,
   input  logic              full,
   input  logic [BYTE_W-1:0] hold,
   output logic              take,
   output logic              line_bit,
   output logic              tone_on,
   output logic [ACC_W-1:0]  step
);
   localparam int BIT_CYC = (F_CLK + BAUD / 2) / BAUD;
   localparam int TMR_W   = $clog2(BIT_CYC);
   localparam int IDX_W   = $clog2(BYTE_W + 2);
   localparam int ICNT_W  = $clog2(IDLE_MIN + 1);
   localparam logic [ACC_W-1:0] STEP_MA = ACC_W'(tone_step(MARK_A_HZ, F_CLK, ACC_W));
   localparam logic [ACC_W-1:0] STEP_SA = ACC_W'(tone_step(SPACE_A_HZ, F_CLK, ACC_W));
   localparam logic [ACC_W-1:0] STEP_MB = ACC_W'(tone_step(MARK_B_HZ, F_CLK, ACC_W));
   localparam logic [ACC_W-1:0] STEP_SB = ACC_W'(tone_step(SPACE_B_HZ, F_CLK, ACC_W));

   tx_state_e          st_q;
   logic [TMR_W-1:0]   tmr_q;
   logic [IDX_W-1:0]   idx_q;
   logic [ICNT_W-1:0]  icnt_q;
   logic [BYTE_W-1:0]  txsr_q;
   logic               line_q;
   logic [ACC_W-1:0]   step_q;
   logic               at_edge;
   logic               take_c;

   function automatic logic [ACC_W-1:0] pick_step(input logic b, input logic p);
      if (p) return b ? STEP_MA : STEP_SA;
      else   return b ? STEP_MB : STEP_SB;
   endfunction

   assign at_edge  = (tmr_q == TMR_W'(BIT_CYC - 1));
   assign tone_on  = (st_q == ST_PRE) || (st_q == ST_IDLE) || (st_q == ST_DATA);
   assign line_bit = line_q;
   assign step     = step_q;
   assign take     = take_c;

   always_comb begin
      take_c = 1'b0;
      if (send_en && full) begin
         if (st_q == ST_WAIT)
            take_c = 1'b1;
         else if (at_edge)
            take_c = (st_q == ST_PRE)
                  || (st_q == ST_IDLE && icnt_q >= ICNT_W'(IDLE_MIN - 1))
                  || (st_q == ST_DATA && idx_q == IDX_W'(BYTE_W + 1));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_OFF;
         tmr_q  <= '0;
         idx_q  <= '0;
         icnt_q <= '0;
         txsr_q <= '0;
         line_q <= 1'b1;
         step_q <= '0;
      end else if (!send_en) begin
         st_q   <= ST_OFF;
         tmr_q  <= '0;
         idx_q  <= '0;
         icnt_q <= '0;
         line_q <= 1'b1;
         step_q <= pick_step(1'b1, plan_sel);
      end else if (take_c) begin
         st_q   <= ST_DATA;
         tmr_q  <= '0;
         idx_q  <= '0;
         txsr_q <= hold;
         line_q <= 1'b0;
         step_q <= pick_step(1'b0, plan_sel);
      end else begin
         case (st_q)
            ST_OFF: begin
               st_q   <= pre_hold ? ST_WAIT : ST_PRE;
               step_q <= pick_step(1'b1, plan_sel);
            end
            ST_WAIT: st_q <= ST_WAIT;
            default: begin
               tmr_q <= at_edge ? '0 : tmr_q + TMR_W'(1);
               if (at_edge) begin
                  if (st_q == ST_DATA && idx_q < IDX_W'(BYTE_W)) begin
                     line_q <= txsr_q[0];
                     step_q <= pick_step(txsr_q[0], plan_sel);
                     txsr_q <= txsr_q >> 1;
                     idx_q  <= idx_q + IDX_W'(1);
                  end else begin
                     line_q <= 1'b1;
                     step_q <= pick_step(1'b1, plan_sel);
                     if (st_q == ST_DATA) begin
                        if (idx_q == IDX_W'(BYTE_W)) begin
                           idx_q <= idx_q + IDX_W'(1);
                        end else begin
                           st_q   <= ST_IDLE;
                           icnt_q <= '0;
                        end
                     end else if (st_q == ST_IDLE && icnt_q < ICNT_W'(IDLE_MIN - 1)) begin
                        icnt_q <= icnt_q + ICNT_W'(1);
                     end
                  end
               end
            end
         endcase
      end
   end

   AST_BIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (tone_on && tmr_q != '0) |-> $stable(line_q)) else $error("line moved mid-bit"); // R3
   AST_STEP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_q != '0) |-> $stable(step_q)) else $error("tone changed mid-bit"); // R7
   AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st_q) == ST_IDLE && st_q == ST_DATA) |-> ($past(icnt_q) == ICNT_W'(IDLE_MIN - 1)))
      else $error("idle gap too short"); // R4
   AST_OFF_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(send_en) |-> (line_q && !tone_on)) else $error("output active while disabled"); // R9
endmodule

// File: rtl/fsk_tone_nco.sv
module fsk_tone_nco #(
   parameter int ACC_W  = 24,
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_n,
   input  logic              run,
   input  logic [ACC_W-1:0]  step,
   output logic              tone_msb,
   output logic [CODE_W-1:0] tone_code
);
   logic [ACC_W-1:0] acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        acc_q <= '0;
      else if (!clear_n) acc_q <= '0;
      else if (run)      acc_q <= acc_q + step;
   end

   assign tone_msb = acc_q[ACC_W-1];

   generate
      if (CODE_W == 1) begin : g_square
         assign tone_code = acc_q[ACC_W-1];
      end else begin : g_fold
         logic [CODE_W:0] ph;
         assign ph        = acc_q[ACC_W-1 -: CODE_W + 1];
         assign tone_code = ph[CODE_W] ? ~ph[CODE_W-1:0] : ph[CODE_W-1:0];
      end
   endgenerate

   AST_CLEARED_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(clear_n) |-> (acc_q == '0)) else $error("phase not cleared"); // R9
   AST_FROZEN_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(clear_n) && !$past(run)) |-> $stable(acc_q)) else $error("phase moved while stopped"); // R6
endmodule

// File: rtl/fsk_tx_framer.sv
module fsk_tx_framer #(
   parameter int F_CLK      = 3579545,
   parameter int BAUD       = 1200,
   parameter int ACC_W      = 24,
   parameter int CODE_W     = 8,
   parameter int IDLE_MIN   = 5,
   parameter int SYNC_LEN   = 2,
   parameter int MARK_A_HZ  = 1200,
   parameter int SPACE_A_HZ = 2204,
   parameter int MARK_B_HZ  = 1300,
   parameter int SPACE_B_HZ = 2101
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              send_en,
   input  logic              pre_hold,
   input  logic              plan_sel,
   input  logic              ser_clk,
   input  logic              ser_data,
   output logic              ready,
   output logic              line_bit,
   output logic              tone_on,
   output logic              tone_msb,
   output logic [CODE_W-1:0] tone_code
);
   localparam int BYTE_W = 8;

   generate
      if (ACC_W < 16 || ACC_W > 32) begin : g_bad_acc
         $error("ACC_W must lie in 16..32");
      end
      if (CODE_W < 1 || CODE_W >= ACC_W) begin : g_bad_code
         $error("CODE_W must lie in 1..ACC_W-1");
      end
      if (IDLE_MIN < 2) begin : g_bad_idle
         $error("IDLE_MIN must be at least 2");
      end
      if (SYNC_LEN < 2) begin : g_bad_sync
         $error("SYNC_LEN must be at least 2");
      end
      if (F_CLK / BAUD < 4) begin : g_bad_rate
         $error("bit period too short");
      end
   endgenerate

   logic              full;
   logic [BYTE_W-1:0] hold;
   logic              take;
   logic [ACC_W-1:0]  step;

   fsk_host_rx #(.SYNC_LEN(SYNC_LEN), .BYTE_W(BYTE_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
      .take(take), .full(full), .hold(hold)
   );

   fsk_frame_seq #(
      .F_CLK(F_CLK), .BAUD(BAUD), .ACC_W(ACC_W), .IDLE_MIN(IDLE_MIN), .BYTE_W(BYTE_W),
      .MARK_A_HZ(MARK_A_HZ), .SPACE_A_HZ(SPACE_A_HZ),
      .MARK_B_HZ(MARK_B_HZ), .SPACE_B_HZ(SPACE_B_HZ)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .send_en(send_en), .pre_hold(pre_hold),
      .plan_sel(plan_sel), .full(full), .hold(hold), .take(take),
      .line_bit(line_bit), .tone_on(tone_on), .step(step)
   );

   fsk_tone_nco #(.ACC_W(ACC_W), .CODE_W(CODE_W)) u_nco (
      .clk(clk), .rst_n(rst_n), .clear_n(send_en), .run(tone_on), .step(step),
      .tone_msb(tone_msb), .tone_code(tone_code)
   );

   assign ready = !full;
endmodule

// File: tb/fsk_tx_framer_test.sv
module fsk_tx_framer_test;
   localparam int  BC   = 2983;
   localparam longint FCLK = 3579545;

   logic clk = 1'b0, rst_n = 1'b0;
   logic send_en = 1'b0, pre_hold = 1'b0, plan_sel = 1'b1;
   logic ser_clk = 1'b0, ser_data = 1'b0;
   logic ready, line_bit, tone_on, tone_msb;
   logic [7:0] tone_code;

   int n_chk = 0, n_bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   fsk_tx_framer uut (
      .clk(clk), .rst_n(rst_n), .send_en(send_en), .pre_hold(pre_hold),
      .plan_sel(plan_sel), .ser_clk(ser_clk), .ser_data(ser_data),
      .ready(ready), .line_bit(line_bit), .tone_on(tone_on),
      .tone_msb(tone_msb), .tone_code(tone_code)
   );

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   function automatic longint step_of(input longint f);
      return ((f << 24) + FCLK / 2) / FCLK;
   endfunction

   // ---------------- behavioural reference ----------------
   // modes: 0 off, 1 silent wait, 2 mark run, 3 idle gap, 4 in frame
   int      m_mode = 0, m_tmr = 0, m_pos = 0, m_gap = 0, m_cnt = 0;
   bit      m_line = 1, m_full = 0;
   longint  m_step = 0, m_acc = 0;
   int      m_byte = 0, m_asm = 0, m_sr = 0;
   bit      ck_hist[$] = '{0, 0, 0};
   bit      dt_hist[$] = '{0, 0, 0};

   function automatic longint tone_for(input bit b, input bit p);
      if (p) return b ? step_of(1200) : step_of(2204);
      else   return b ? step_of(1300) : step_of(2101);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mode = 0; m_tmr = 0; m_pos = 0; m_gap = 0; m_cnt = 0;
         m_line = 1; m_full = 0; m_step = 0; m_acc = 0; m_asm = 0; m_byte = 0; m_sr = 0;
         ck_hist = '{0, 0, 0}; dt_hist = '{0, 0, 0};
      end else begin
         bit rise, db, bnd, tk;
         rise = ck_hist[1] && !ck_hist[2];
         db   = dt_hist[1];
         bnd  = (m_tmr == BC - 1);
         tk   = m_full && send_en &&
                (m_mode == 1 || (bnd && (m_mode == 2 || (m_mode == 3 && m_gap >= 4) ||
                                         (m_mode == 4 && m_pos == 9))));
         if (!send_en) m_acc = 0;
         else if (m_mode >= 2) m_acc = (m_acc + m_step) % (64'd1 << 24);
         if (tk) m_full = 0;
         else if (rise && !m_full) begin
            m_asm = (m_asm >> 1) | (int'(db) << 7);
            m_cnt++;
            if (m_cnt == 8) begin m_byte = m_asm; m_full = 1; m_cnt = 0; end
         end
         if (!send_en) begin
            m_mode = 0; m_tmr = 0; m_pos = 0; m_gap = 0; m_line = 1;
            m_step = tone_for(1, plan_sel);
         end else if (tk) begin
            m_mode = 4; m_tmr = 0; m_pos = 0; m_sr = m_byte; m_line = 0;
            m_step = tone_for(0, plan_sel);
         end else if (m_mode == 0) begin
            m_mode = pre_hold ? 1 : 2;
            m_step = tone_for(1, plan_sel);
         end else if (m_mode >= 2) begin
            m_tmr = bnd ? 0 : m_tmr + 1;
            if (bnd) begin
               if (m_mode == 4 && m_pos < 8) begin
                  m_line = m_sr[0]; m_sr = m_sr >> 1; m_pos++;
               end else begin
                  m_line = 1;
                  if (m_mode == 4) begin
                     if (m_pos == 8) m_pos++;
                     else begin m_mode = 3; m_gap = 0; end
                  end else if (m_mode == 3 && m_gap < 4) m_gap++;
               end
               m_step = tone_for(m_line, plan_sel);
            end
         end
         ck_hist.push_front(ser_clk); void'(ck_hist.pop_back());
         dt_hist.push_front(ser_data); void'(dt_hist.pop_back());
      end
   end

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int ph, code;
         ph   = int'((m_acc >> 15) & 511);
         code = (ph >= 256) ? 255 - (ph & 255) : (ph & 255);
         check(ready == !m_full, "R2 ready", ready, !m_full);
         check(line_bit == m_line, "R3 line_bit", line_bit, m_line);
         check(tone_on == (m_mode >= 2), "R5/R6 tone_on", tone_on, m_mode >= 2);
         check(tone_msb == m_acc[23], "R7 tone_msb", tone_msb, m_acc[23]);
         check(tone_code == code, "R8 tone_code", tone_code, code);
      end
   end

   // ---------------- independent line decoder ----------------
   int dec_byte[8];
   int dec_start[8];
   int n_dec = 0;

   initial begin
      bit prev = 1;
      forever begin
         @(negedge clk);
         if (rst_n && tone_on && prev && !line_bit) begin
            int st, b;
            st = cyc; b = 0;
            repeat (BC / 2) @(negedge clk);
            for (int i = 0; i < 8; i++) begin
               repeat (BC) @(negedge clk);
               b |= int'(line_bit) << i;
            end
            repeat (BC) @(negedge clk);
            check(line_bit == 1'b1, "R3 stop bit", line_bit, 1);
            if (n_dec < 8) begin dec_byte[n_dec] = b; dec_start[n_dec] = st; end
            n_dec++;
            prev = 1;
         end else begin
            prev = line_bit;
         end
      end
   end

   task automatic write_byte(input logic [7:0] b);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk); ser_data = b[i];
         repeat (4) @(negedge clk); ser_clk = 1'b1;
         repeat (4) @(negedge clk); ser_clk = 1'b0;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin : watchdog
      idle(190000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      int wr_a, wr_b;
      idle(5);
      check(ready && line_bit && !tone_on && !tone_msb && tone_code == 0, "R1 in reset",
            {ready, line_bit, tone_on, tone_msb}, 4'b1100);
      rst_n = 1'b1;
      idle(5);
      check(ready && line_bit && !tone_on && tone_code == 0, "R1 after reset",
            {ready, line_bit, tone_on}, 3'b110);

      // tone plan 1, mark run on entry
      plan_sel = 1'b1; pre_hold = 1'b0; send_en = 1'b1;
      idle(2 * BC);
      check(tone_on && line_bit, "R5 mark run", {tone_on, line_bit}, 2'b11);
      write_byte(8'hA5);
      wr_a = cyc;
      idle(6);
      check(!ready, "R2 ready low after eighth bit", ready, 0);
      while (!ready) @(negedge clk);
      write_byte(8'h3C);
      idle(6);
      check(!ready, "R2 second byte pending", ready, 0);
      write_byte(8'hFF);            // ignored: slot full
      while (n_dec < 2) @(negedge clk);
      idle(BC);
      write_byte(8'h81);
      while (n_dec < 3) @(negedge clk);
      idle(BC);

      check(dec_start[0] - wr_a <= BC + 4, "R5 first start within one bit",
            dec_start[0] - wr_a, BC);
      check(dec_byte[0] == 8'hA5, "R3 byte 0", dec_byte[0], 8'hA5);
      check(dec_byte[1] == 8'h3C, "R2 byte written while full ignored", dec_byte[1], 8'h3C);
      check(dec_start[1] - dec_start[0] == 10 * BC, "R4 back-to-back spacing",
            dec_start[1] - dec_start[0], 10 * BC);
      check(dec_byte[2] == 8'h81, "R3 byte 2", dec_byte[2], 8'h81);
      check(dec_start[2] - dec_start[1] == 15 * BC, "R4 five idle bits",
            dec_start[2] - dec_start[1], 15 * BC);

      // leave send mode
      send_en = 1'b0;
      idle(3);
      check(!tone_on && line_bit && tone_code == 0 && !tone_msb, "R9 disabled outputs",
            {tone_on, line_bit, tone_msb}, 3'b010);

      // tone plan 0, silent entry
      plan_sel = 1'b0; pre_hold = 1'b1;
      idle(5);
      send_en = 1'b1;
      idle(500);
      check(!tone_on && tone_code == 0, "R6 silent before first byte", tone_on, 0);
      write_byte(8'h5A);
      wr_b = cyc;
      while (n_dec < 4) @(negedge clk);
      check(dec_start[3] - wr_b <= 6, "R6 start follows write", dec_start[3] - wr_b, 4);
      check(dec_byte[3] == 8'h5A, "R7 byte on second plan", dec_byte[3], 8'h5A);
      idle(BC);
      send_en = 1'b0;
      idle(2);
      check(!tone_on && line_bit && tone_code == 0, "R9 abort in idle",
            {tone_on, line_bit}, 2'b01);
      check(n_dec == 4, "R2 no extra bytes sent", n_dec, 4);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end
endmodule